// File: doc/BRIEF.md
# Wavefront Crossbar Arbiter

This block chooses, once per clock, which inputs of an N×N crossbar are connected to which outputs. It takes a request matrix in which bit `req[i*N+j]` set means input `i` holds a cell for output `j`. It returns a match matrix with the same bit layout, in which every input and every output is used at most once. The decision comes from a grid of identical combinational cells. Two "still free" tokens pass through the grid: one along each row and one along each column. A cell grants when it sees a request and holds both tokens. Once it grants, it withdraws both tokens from every cell evaluated after it.

The grid is evaluated in waves of cells. No two cells in a wave share a row or a column, so each wave resolves in parallel. The `WRAPPED` parameter picks one of two wave layouts:
- **Wrapped layout.** Cells are grouped by `(i+j) mod N` into N waves.
- **Plain layout.** Cells are grouped by their row distance plus column, into 2N-1 waves.

A priority pointer selects which diagonal, or which row, is served first. The pointer moves on every clock, so no fixed cell keeps first choice. The match result is registered and appears one clock after the request.

Top module: `wfa_arbiter`

## Requirements
- R1: A match bit is set only where the corresponding request bit was set on the clock edge that produced it. The result appears one clock after the request is presented.
- R2: Each row (input) of the match matrix holds at most one set bit.
- R3: Each column (output) of the match matrix holds at most one set bit.
- R4: The match is maximal. For every request bit (i,j) that was set, the resulting match has a grant somewhere in row i or in column j.
- R5: An all-zero request matrix yields an all-zero match on the next clock.
- R6: Wrapped layout (`WRAPPED=1`): cell (i,j) belongs to diagonal `(i+j) mod N`. Diagonals are served in the order p, p+1, …, wrapping modulo N, where p is the priority pointer. A cell grants only if its row and its column are not taken by a cell on an earlier-served diagonal.
- R7: The priority pointer is 0 on the first clock after reset release. It advances by one on every clock and wraps from N-1 to 0.
- R8: Plain layout (`WRAPPED=0`): row i is renumbered `r = (i - p) mod N`. Cells are served in ascending wave `r + j`, from 0 to 2N-2. A cell on a lower wave takes its row and column first.
- R9: While `rst_n` is low, the match output is all zero. Asserting reset clears it at once, without waiting for a clock.
- R10: With every request bit set, the wrapped layout grants exactly the cells with `(i+j) mod N = p`. The plain layout grants exactly the cells with `(i - p) mod N = j`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, release aligned to `clk` upstream |
| req | input | N*N | Request matrix, bit i*N+j = input i wants output j |
| match | output | N*N | Registered match matrix, same bit layout as `req` |

## Verification
A broken token link or a mis-wired rotation shows up as a double grant in a row or column, or as a request left idle while both its row and its column are empty. Either error is visible in the very next registered match. A priority pointer that is stuck or skips a step changes which diagonal wins a full or conflicting request. Stepping a full matrix through N consecutive clocks reveals that within N cycles. Reset faults show as a nonzero match while reset is held, or as the wrong winning diagonal on the first clock after release.

// File: rtl/wfa_pkg.sv
package wfa_pkg;

  // (a + b) mod n for 0 <= a,b < n
  function automatic int wrap_add(int a, int b, int n);
    int s;
    s = a + b;
    return (s >= n) ? s - n : s;
  endfunction

  // (a - b) mod n for 0 <= a,b < n
  function automatic int wrap_sub(int a, int b, int n);
    return (a >= b) ? a - b : a + n - b;
  endfunction

endpackage

// File: rtl/wfa_cell.sv
module wfa_cell (
  input  logic req,
  input  logic row_free_i,
  input  logic col_free_i,
  output logic grant,
  output logic row_free_o,
  output logic col_free_o
);
  assign grant      = req & row_free_i & col_free_i;
  assign row_free_o = row_free_i & ~grant;
  assign col_free_o = col_free_i & ~grant;
endmodule

// File: rtl/wfa_prio.sv
module wfa_prio #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] prio
);
  logic [PW-1:0] prio_q;
  logic [PW-1:0] prio_d;

  always_comb begin
    if (prio_q == PW'(N - 1)) prio_d = '0;
    else                      prio_d = prio_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prio_q <= '0;
    else        prio_q <= prio_d;
  end

  assign prio = prio_q;
endmodule

// File: rtl/wfa_rowrot.sv
module wfa_rowrot #(
  parameter int N    = 4,
  parameter int PW   = 2,
  parameter bit BACK = 1'b0
) (
  input  logic [N*N-1:0] din,
  input  logic [PW-1:0]  sel,
  output logic [N*N-1:0] dout
);
  import wfa_pkg::*;

  always_comb begin
    dout = '0;
    for (int r = 0; r < N; r++) begin
      int src;
      if (BACK) src = wrap_sub(r, int'(sel), N);
      else      src = wrap_add(r, int'(sel), N);
      dout[r*N +: N] = din[src*N +: N];
    end
  end
endmodule

// File: rtl/wfa_array.sv
module wfa_array #(
  parameter int N       = 4,
  parameter bit WRAPPED = 1'b1
) (
  input  logic [N*N-1:0] req,
  output logic [N*N-1:0] grant
);
  logic rf_in  [N][N];
  logic cf_in  [N][N];
  logic rf_out [N][N];
  logic cf_out [N][N];

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      wfa_cell u_cell (
        .req        (req[i*N+j]),
        .row_free_i (rf_in[i][j]),
        .col_free_i (cf_in[i][j]),
        .grant      (grant[i*N+j]),
        .row_free_o (rf_out[i][j]),
        .col_free_o (cf_out[i][j])
      );
    end
  end

  if (WRAPPED) begin : g_wrap
    for (genvar i = 0; i < N; i++) begin : g_wr
      for (genvar j = 0; j < N; j++) begin : g_wc
        localparam int JP = (j + N - 1) % N;
        localparam int IP = (i + N - 1) % N;
        if (((i + j) % N) == 0) begin : g_head
          assign rf_in[i][j] = 1'b1;
          assign cf_in[i][j] = 1'b1;
        end else begin : g_link
          assign rf_in[i][j] = rf_out[i][JP];
          assign cf_in[i][j] = cf_out[IP][j];
        end
      end
    end
  end else begin : g_plain
    for (genvar i = 0; i < N; i++) begin : g_pr
      for (genvar j = 0; j < N; j++) begin : g_pc
        if (j == 0) begin : g_rhead
          assign rf_in[i][j] = 1'b1;
        end else begin : g_rlink
          assign rf_in[i][j] = rf_out[i][j-1];
        end
        if (i == 0) begin : g_chead
          assign cf_in[i][j] = 1'b1;
        end else begin : g_clink
          assign cf_in[i][j] = cf_out[i-1][j];
        end
      end
    end
  end
endmodule

// File: rtl/wfa_arbiter.sv
module wfa_arbiter #(
  parameter int N       = 4,
  parameter bit WRAPPED = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N*N-1:0] req,
  output logic [N*N-1:0] match
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0]  prio;
  logic [N*N-1:0] req_rot;
  logic [N*N-1:0] grant_rot;
  logic [N*N-1:0] match_d;
  logic [N*N-1:0] match_q;

  wfa_prio #(.N(N), .PW(PW)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .prio  (prio)
  );

  wfa_rowrot #(.N(N), .PW(PW), .BACK(1'b0)) u_rot_in (
    .din  (req),
    .sel  (prio),
    .dout (req_rot)
  );

  wfa_array #(.N(N), .WRAPPED(WRAPPED)) u_array (
    .req   (req_rot),
    .grant (grant_rot)
  );

  wfa_rowrot #(.N(N), .PW(PW), .BACK(1'b1)) u_rot_out (
    .din  (grant_rot),
    .sel  (prio),
    .dout (match_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= '0;
    else        match_q <= match_d;
  end

  assign match = match_q;
endmodule

// File: rtl/wfa_arbiter_chk.sv
module wfa_arbiter_chk #(
  parameter int N       = 4,
  parameter bit WRAPPED = 1'b1
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [N*N-1:0]                      req,
  input logic [N*N-1:0]                      match,
  input logic [((N > 1) ? $clog2(N) : 1)-1:0] prio
);
  import wfa_pkg::*;

  logic [N-1:0] col_any;

  always_comb begin
    col_any = '0;
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        col_any[j] = col_any[j] | match[i*N+j];
  end

  function automatic logic [N*N-1:0] full_mask(int p);
    logic [N*N-1:0] m;
    m = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (WRAPPED) m[i*N+j] = (((i + j) % N) == p);
        else         m[i*N+j] = (wrap_sub(i, p, N) == j);
    return m;
  endfunction

  assert_grant_subset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((match & ~$past(req)) == '0));

  for (genvar i = 0; i < N; i++) begin : g_rowchk
    assert_row_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match[i*N +: N]));
  end

  for (genvar j = 0; j < N; j++) begin : g_colchk
    logic [N-1:0] colv;
    always_comb
      for (int i = 0; i < N; i++) colv[i] = match[i*N+j];
    assert_col_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(colv));
  end

  for (genvar i = 0; i < N; i++) begin : g_maxr
    for (genvar j = 0; j < N; j++) begin : g_maxc
      assert_maximal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req[i*N+j] |=> ((|match[i*N +: N]) || col_any[j]));
    end
  end

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (match == '0));

  assert_full_diag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '1) |=> (match == full_mask(int'($past(prio)))));

endmodule

bind wfa_arbiter wfa_arbiter_chk #(.N(N), .WRAPPED(WRAPPED)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .req   (req),
  .match (match),
  .prio  (prio)
);

// File: tb/wfa_arbiter_tb.sv
`timescale 1ns/1ps
module wfa_arbiter_tb;
  localparam int N  = 4;
  localparam int NN = N * N;

  logic          clk;
  logic          rst_n;
  logic [NN-1:0] req;
  logic [NN-1:0] match_w;
  logic [NN-1:0] match_p;

  int  tests = 0;
  int  fails = 0;
  int  bptr  = 0;
  bit  done  = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  wfa_arbiter #(.N(N), .WRAPPED(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .match(match_w));

  wfa_arbiter #(.N(N), .WRAPPED(1'b0)) u_dut_plain (
    .clk(clk), .rst_n(rst_n), .req(req), .match(match_p));

  // {pointer, request, expected wrapped match}
  localparam logic [35:0] VEC [10] = '{
    {4'd0, 16'hFFFF, 16'h2481},
    {4'd1, 16'hFFFF, 16'h4812},
    {4'd0, 16'h0003, 16'h0001},
    {4'd1, 16'h0003, 16'h0002},
    {4'd3, 16'h0003, 16'h0001},
    {4'd0, 16'h4040, 16'h4000},
    {4'd2, 16'h4040, 16'h0040},
    {4'd2, 16'h0000, 16'h0000},
    {4'd0, 16'h0013, 16'h0001},
    {4'd1, 16'h0013, 16'h0012}
  };

  function automatic logic [NN-1:0] ref_match(logic [NN-1:0] r, int p, bit wrapped);
    logic [NN-1:0] m;
    logic [N-1:0]  rt;
    logic [N-1:0]  ct;
    m = '0; rt = '0; ct = '0;
    if (wrapped) begin
      for (int w = 0; w < N; w++) begin
        int d;
        d = (p + w) % N;
        for (int i = 0; i < N; i++) begin
          int j;
          j = (d - i + N) % N;
          if (r[i*N+j] && !rt[i] && !ct[j]) begin
            m[i*N+j] = 1'b1; rt[i] = 1'b1; ct[j] = 1'b1;
          end
        end
      end
    end else begin
      for (int w = 0; w < 2*N-1; w++) begin
        for (int rr = 0; rr < N; rr++) begin
          int j;
          int i;
          j = w - rr;
          i = (rr + p) % N;
          if (j >= 0 && j < N) begin
            if (r[i*N+j] && !rt[i] && !ct[j]) begin
              m[i*N+j] = 1'b1; rt[i] = 1'b1; ct[j] = 1'b1;
            end
          end
        end
      end
    end
    return m;
  endfunction

  task automatic chk(string tag, logic [NN-1:0] act, logic [NN-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(string tag, bit ok);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0 expected=1", tag);
    end
  endtask

  // structural checks of a match against the request that produced it
  task automatic chk_struct(logic [NN-1:0] r, logic [NN-1:0] m);
    bit ok1, ok2, ok3, ok4;
    ok1 = ((m & ~r) == '0);
    ok2 = 1; ok3 = 1; ok4 = 1;
    for (int i = 0; i < N; i++) begin
      int c;
      c = 0;
      for (int j = 0; j < N; j++) c += m[i*N+j];
      if (c > 1) ok2 = 0;
    end
    for (int j = 0; j < N; j++) begin
      int c;
      c = 0;
      for (int i = 0; i < N; i++) c += m[i*N+j];
      if (c > 1) ok3 = 0;
    end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (r[i*N+j]) begin
          bit busy;
          busy = 0;
          for (int k = 0; k < N; k++) busy |= m[i*N+k] | m[k*N+j];
          if (!busy) ok4 = 0;
        end
    chk_bit("R1 grant without request", ok1);
    chk_bit("R2 row grants", ok2);
    chk_bit("R3 column grants", ok3);
    chk_bit("R4 maximality", ok4);
  endtask

  // drive at a falling edge, one rising edge, back at the falling edge
  task automatic step(logic [NN-1:0] r, output logic [NN-1:0] ew, output logic [NN-1:0] ep);
    req = r;
    ew  = ref_match(r, bptr, 1'b1);
    ep  = ref_match(r, bptr, 1'b0);
    @(posedge clk);
    bptr = (bptr + 1) % N;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [NN-1:0] ew, ep;
    logic [15:0]   lfsr;

    // R9: reset holds the match at zero even with full requests
    rst_n = 1'b0;
    req   = '1;
    repeat (3) @(negedge clk);
    chk("R9 reset wrapped", match_w, '0);
    chk("R9 reset plain",   match_p, '0);
    rst_n = 1'b1;
    bptr  = 0;

    // R7/R10: full matrix walks the priority through every value
    for (int k = 0; k < N + 1; k++) begin
      step('1, ew, ep);
      chk("R7 R10 full wrapped", match_w, ew);
      chk("R7 R10 full plain",   match_p, ep);
    end

    // R6/R5/R10: table of hand-computed wrapped results
    for (int v = 0; v < 10; v++) begin
      int p;
      p = int'(VEC[v][35:32]);
      while (bptr != p) begin
        step('0, ew, ep);
        chk("R5 idle wrapped", match_w, '0);
      end
      step(VEC[v][31:16], ew, ep);
      chk("R6 table wrapped", match_w, VEC[v][15:0]);
      chk("R8 table plain",   match_p, ep);
    end

    // R8: plain layout, pointer 1, full request -> rows shifted diagonal
    while (bptr != 1) step('0, ew, ep);
    step('1, ew, ep);
    chk("R8 R10 plain full p1", match_p, 16'h4218);

    // R1-R6, R8: pseudo-random patterns of varying density
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      logic [NN-1:0] r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (k % 3)
        0: r = lfsr;
        1: r = lfsr & {lfsr[7:0], lfsr[15:8]};
        default: r = lfsr | {lfsr[3:0], lfsr[15:4]};
      endcase
      step(r, ew, ep);
      chk("R6 random wrapped", match_w, ew);
      chk("R8 random plain",   match_p, ep);
      chk_struct(r, match_w);
      chk_struct(r, match_p);
    end

    // R5: zero request after busy traffic
    step('0, ew, ep);
    chk("R5 zero wrapped", match_w, '0);
    chk("R5 zero plain",   match_p, '0);

    // R9: asynchronous clear mid-cycle, then R7 restart from pointer 0
    req = '1;
    @(posedge clk);
    #5;
    chk_bit("R9 match busy before reset", match_w != '0);
    rst_n = 1'b0;
    #1;
    chk("R9 async clear wrapped", match_w, '0);
    chk("R9 async clear plain",   match_p, '0);
    @(negedge clk);
    @(negedge clk);
    chk("R9 held wrapped", match_w, '0);
    rst_n = 1'b1;
    bptr  = 0;
    step('1, ew, ep);
    chk("R7 restart wrapped", match_w, 16'h2481);
    chk("R7 restart plain",   match_p, 16'h8421);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule